// File: doc/BRIEF.md
# Trap and Interrupt Entry Controller

This block sits beside a processor pipeline and decides, cycle by cycle, whether control must leave the running program. A synchronous trap request arrives as a one-cycle strobe carrying a cause code, the PC of the faulting instruction, its instruction word and a flag for translation refill. External interrupt lines are sampled every cycle. When an entry is taken, the block updates its mode, saved-state, status and debug registers. One cycle later it drives a single-cycle redirect with the new fetch address.

There are three entry paths, and each saves state into its own registers. The normal path covers exceptions and interrupts. The refill path is for translation misses. The debug path is for breakpoints, and also for interrupts that arrive while debug mode is active. Normal entries are vectored: the target is the entry base plus the cause code (or, for an interrupt, an interrupt base code plus the winning line) scaled by a programmable power-of-two spacing. Software sets the mode, configuration, entry bases and debug flags through a single-cycle write port.

Top module: `trap_entry_ctrl`

## Requirements
- R1: An interrupt entry is taken only when interrupt enable (`ie_o`) is 1, no trap is requested in that cycle, and `irq_lines_i & lie` is nonzero. The normal vector is used only when debug mode is 0. The local enable mask `lie` is config write bits [NUM_IRQ-1:0].
- R2: When several unmasked lines are pending, the highest-numbered line selects the vector.
- R3: The spacing field `vs` is config write bits [18:16]. A normal exception redirects to `base` when `vs` is 0, and otherwise to `base + (cause << (vs+2))`.
- R4: An interrupt redirects to `base + ((INT_BASE + line) << (vs+2))`, or to `base` when `vs` is 0. `INT_BASE` defaults to 64. It writes 0 into `ecode_o` and `cur_pc_i` into `epc_o`.
- R5: A normal or refill entry copies the privilege level and interrupt enable into a saved pair, then clears both. A debug entry leaves the privilege level and interrupt enable unchanged.
- R6: A refill trap (`trap_refill_i`=1, cause not 26) saves the privilege level and interrupt enable into `rf_sv_plv_o`/`rf_sv_ie_o`. It sets `da_o`=1, sets `pg_o`=0, stores `trap_pc_i[AW-1:2]` in `rf_epc_o`, and redirects to the refill base. It leaves `ecode_o` and `epc_o` unchanged.
- R7: A non-refill trap writes its cause into `ecode_o` and `trap_pc_i` into `epc_o`.
- R8: Cause 26 (breakpoint) takes priority over the refill flag. It sets `dbg_bkpt_o` and `dbg_mode_o`, writes 0xC into `dbg_ecode_o` and `trap_pc_i` into `depc_o`, and redirects to `base + 0x480`.
- R9: In debug mode with interrupt enable 1, an unmasked pending interrupt sets `dbg_irq_o`, stores `cur_pc_i` in `depc_o`, and redirects to `base + 0x480`. No further debug interrupt entry is taken while `dbg_irq_o` is 1.
- R10: Causes 11 to 16 load `trap_pc_i` into `badv_o`. Every trap except cause 3 (fetch page invalid) loads `trap_insn_i` into `badi_o`. Interrupt entries touch neither register.
- R11: Reset state:
  - `new_pc_o` is 0x1C000000 and `redirect_o` is 0;
  - privilege level 0, interrupt enable 0, `da_o` 1, `pg_o` 0;
  - `vs` 0 and `lie` 0.
- R12: `redirect_o` pulses for one cycle, in the cycle after the entry decision. A trap wins over a pending interrupt in the same cycle. A register write in an entry cycle is dropped.
- R13: Write select codes:
  - 0 is mode: [1:0] privilege level, [2] interrupt enable, [3] `da`, [4] `pg`;
  - 1 is config;
  - 2 is entry base;
  - 3 is refill base;
  - 4 is debug: [0] mode, [1] breakpoint flag, [2] interrupt flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| trap_valid_i | input | 1 | One-cycle trap request |
| trap_cause_i | input | 6 | Trap cause code (nonzero) |
| trap_pc_i | input | AW | PC of the faulting instruction |
| trap_insn_i | input | IW | Faulting instruction word |
| trap_refill_i | input | 1 | Trap is a translation refill |
| cur_pc_i | input | AW | PC saved when an interrupt is taken |
| irq_lines_i | input | NUM_IRQ | Pending interrupt lines |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 3 | Register write select |
| wr_data_i | input | AW | Register write data |
| redirect_o | output | 1 | Redirect pulse |
| new_pc_o | output | AW | Redirect target |
| plv_o | output | 2 | Current privilege level |
| ie_o | output | 1 | Global interrupt enable |
| da_o | output | 1 | Direct-address mode |
| pg_o | output | 1 | Paging enable |
| sv_plv_o | output | 2 | Saved privilege level, normal path |
| sv_ie_o | output | 1 | Saved interrupt enable, normal path |
| rf_sv_plv_o | output | 2 | Saved privilege level, refill path |
| rf_sv_ie_o | output | 1 | Saved interrupt enable, refill path |
| ecode_o | output | 6 | Exception code field |
| epc_o | output | AW | Exception return address |
| rf_epc_o | output | AW-2 | Refill return address, word granular |
| badv_o | output | AW | Bad address register |
| badi_o | output | IW | Bad instruction register |
| dbg_mode_o | output | 1 | Debug mode active |
| dbg_bkpt_o | output | 1 | Debug entry by breakpoint |
| dbg_irq_o | output | 1 | Debug entry by interrupt |
| dbg_ecode_o | output | 6 | Debug exception code |
| depc_o | output | AW | Debug return address |

## Verification
The assertions assume that `trap_valid_i` never comes with cause 0, which the block reserves for interrupts. They also assume that reset lasts at least one clock. The stimulus drives only the defined nonzero causes and holds every input steady across the sampling edge. All inputs change on the falling edge, which keeps the properties that relate a trap to the next cycle's registers within the same assumptions.

// File: rtl/tec_pkg.sv
package tec_pkg;
  localparam int unsigned CAUSE_W = 6;

  localparam logic [CAUSE_W-1:0] CAUSE_IRQ       = 6'd0;
  localparam logic [CAUSE_W-1:0] CAUSE_IF_PAGE   = 6'd3;
  localparam logic [CAUSE_W-1:0] CAUSE_SYSCALL   = 6'd11;
  localparam logic [CAUSE_W-1:0] CAUSE_BOUND     = 6'd16;
  localparam logic [CAUSE_W-1:0] CAUSE_DBG_BKPT  = 6'd26;
  localparam logic [CAUSE_W-1:0] DBG_CODE_BKPT   = 6'hC;
  localparam int unsigned        DBG_ENTRY_OFS   = 'h480;
  localparam int unsigned        CFG_VS_LSB      = 16;

  typedef enum logic [2:0] {
    ENT_NONE, ENT_EXC, ENT_IRQ, ENT_REFILL, ENT_DBG_BKPT, ENT_DBG_IRQ
  } entry_e;

  typedef enum logic [2:0] {
    WSEL_MODE = 3'd0, WSEL_CFG = 3'd1, WSEL_BASE = 3'd2,
    WSEL_RBASE = 3'd3, WSEL_DBG = 3'd4
  } wsel_e;

  // causes 11..16 record the faulting PC as the bad address
  function automatic logic loads_badv(logic [CAUSE_W-1:0] c);
    return (c >= CAUSE_SYSCALL) && (c <= CAUSE_BOUND);
  endfunction
endpackage

// File: rtl/tec_irq_pick.sv
module tec_irq_pick #(
  parameter int unsigned N  = 13,
  parameter int unsigned LW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  req_i,
  output logic          any_o,
  output logic [LW-1:0] line_o
);
  // later (higher) lines override lower ones
  always_comb begin
    any_o  = |req_i;
    line_o = '0;
    for (int i = 0; i < N; i++) begin
      if (req_i[i]) line_o = LW'(i);
    end
  end
endmodule

// File: rtl/tec_vector.sv
module tec_vector #(
  parameter int unsigned AW     = 32,
  parameter int unsigned CODE_W = 8,
  parameter int unsigned VS_W   = 3
) (
  input  logic [AW-1:0]     base_i,
  input  logic [CODE_W-1:0] code_i,
  input  logic [VS_W-1:0]   vs_i,
  output logic [AW-1:0]     target_o
);
  logic [VS_W:0] sh;
  assign sh       = {1'b0, vs_i} + (VS_W+1)'(2);
  assign target_o = (vs_i == '0) ? base_i : base_i + (AW'(code_i) << sh);
endmodule

// File: rtl/tec_state.sv
module tec_state
  import tec_pkg::*;
#(
  parameter int unsigned AW      = 32,
  parameter int unsigned IW      = 32,
  parameter int unsigned NUM_IRQ = 13,
  parameter int unsigned VS_W    = 3
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  entry_e              kind_i,
  input  logic [CAUSE_W-1:0]  cause_i,
  input  logic [AW-1:0]       ent_pc_i,
  input  logic [IW-1:0]       insn_i,
  input  logic                badv_en_i,
  input  logic                badi_en_i,
  input  logic                wr_en_i,
  input  logic [2:0]          wr_sel_i,
  input  logic [AW-1:0]       wr_data_i,
  output logic [1:0]          plv_o,
  output logic                ie_o,
  output logic                da_o,
  output logic                pg_o,
  output logic [VS_W-1:0]     vs_o,
  output logic [NUM_IRQ-1:0]  lie_o,
  output logic [AW-1:0]       base_o,
  output logic [AW-1:0]       rbase_o,
  output logic [1:0]          sv_plv_o,
  output logic                sv_ie_o,
  output logic [1:0]          rf_sv_plv_o,
  output logic                rf_sv_ie_o,
  output logic [CAUSE_W-1:0]  ecode_o,
  output logic [AW-1:0]       epc_o,
  output logic [AW-3:0]       rf_epc_o,
  output logic [AW-1:0]       badv_o,
  output logic [IW-1:0]       badi_o,
  output logic                dbg_mode_o,
  output logic                dbg_bkpt_o,
  output logic                dbg_irq_o,
  output logic [CAUSE_W-1:0]  dbg_ecode_o,
  output logic [AW-1:0]       depc_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      plv_o <= '0; ie_o <= 1'b0; da_o <= 1'b1; pg_o <= 1'b0;
      vs_o <= '0; lie_o <= '0; base_o <= '0; rbase_o <= '0;
      sv_plv_o <= '0; sv_ie_o <= 1'b0; rf_sv_plv_o <= '0; rf_sv_ie_o <= 1'b0;
      ecode_o <= '0; epc_o <= '0; rf_epc_o <= '0; badv_o <= '0; badi_o <= '0;
      dbg_mode_o <= 1'b0; dbg_bkpt_o <= 1'b0; dbg_irq_o <= 1'b0;
      dbg_ecode_o <= '0; depc_o <= '0;
    end else begin
      unique case (kind_i)
        ENT_EXC, ENT_IRQ: begin
          sv_plv_o <= plv_o;
          sv_ie_o  <= ie_o;
          plv_o    <= '0;
          ie_o     <= 1'b0;
          ecode_o  <= cause_i;
          epc_o    <= ent_pc_i;
        end
        ENT_REFILL: begin
          rf_sv_plv_o <= plv_o;
          rf_sv_ie_o  <= ie_o;
          plv_o       <= '0;
          ie_o        <= 1'b0;
          da_o        <= 1'b1;
          pg_o        <= 1'b0;
          rf_epc_o    <= ent_pc_i[AW-1:2];
        end
        ENT_DBG_BKPT: begin
          dbg_bkpt_o  <= 1'b1;
          dbg_ecode_o <= DBG_CODE_BKPT;
          depc_o      <= ent_pc_i;
          dbg_mode_o  <= 1'b1;
        end
        ENT_DBG_IRQ: begin
          dbg_irq_o  <= 1'b1;
          depc_o     <= ent_pc_i;
          dbg_mode_o <= 1'b1;
        end
        default: begin
          if (wr_en_i) begin
            unique case (wsel_e'(wr_sel_i))
              WSEL_MODE: begin
                plv_o <= wr_data_i[1:0];
                ie_o  <= wr_data_i[2];
                da_o  <= wr_data_i[3];
                pg_o  <= wr_data_i[4];
              end
              WSEL_CFG: begin
                lie_o <= wr_data_i[NUM_IRQ-1:0];
                vs_o  <= wr_data_i[CFG_VS_LSB +: VS_W];
              end
              WSEL_BASE:  base_o  <= wr_data_i;
              WSEL_RBASE: rbase_o <= wr_data_i;
              WSEL_DBG: begin
                dbg_mode_o <= wr_data_i[0];
                dbg_bkpt_o <= wr_data_i[1];
                dbg_irq_o  <= wr_data_i[2];
              end
              default: ;
            endcase
          end
        end
      endcase
      if (badv_en_i) badv_o <= ent_pc_i;
      if (badi_en_i) badi_o <= insn_i;
    end
  end
endmodule

// File: rtl/trap_entry_ctrl.sv
module trap_entry_ctrl
  import tec_pkg::*;
#(
  parameter int unsigned   AW       = 32,
  parameter int unsigned   IW       = 32,
  parameter int unsigned   NUM_IRQ  = 13,
  parameter int unsigned   INT_BASE = 64,
  parameter int unsigned   VS_W     = 3,
  parameter logic [AW-1:0] RESET_PC = 32'h1C00_0000
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                trap_valid_i,
  input  logic [5:0]          trap_cause_i,
  input  logic [AW-1:0]       trap_pc_i,
  input  logic [IW-1:0]       trap_insn_i,
  input  logic                trap_refill_i,
  input  logic [AW-1:0]       cur_pc_i,
  input  logic [NUM_IRQ-1:0]  irq_lines_i,
  input  logic                wr_en_i,
  input  logic [2:0]          wr_sel_i,
  input  logic [AW-1:0]       wr_data_i,
  output logic                redirect_o,
  output logic [AW-1:0]       new_pc_o,
  output logic [1:0]          plv_o,
  output logic                ie_o,
  output logic                da_o,
  output logic                pg_o,
  output logic [1:0]          sv_plv_o,
  output logic                sv_ie_o,
  output logic [1:0]          rf_sv_plv_o,
  output logic                rf_sv_ie_o,
  output logic [5:0]          ecode_o,
  output logic [AW-1:0]       epc_o,
  output logic [AW-3:0]       rf_epc_o,
  output logic [AW-1:0]       badv_o,
  output logic [IW-1:0]       badi_o,
  output logic                dbg_mode_o,
  output logic                dbg_bkpt_o,
  output logic                dbg_irq_o,
  output logic [5:0]          dbg_ecode_o,
  output logic [AW-1:0]       depc_o
);
  localparam int unsigned LW     = (NUM_IRQ > 1) ? $clog2(NUM_IRQ) : 1;
  localparam int unsigned CODE_W = $clog2(INT_BASE + NUM_IRQ + (1 << CAUSE_W));

  logic [VS_W-1:0]    vs;
  logic [NUM_IRQ-1:0] lie;
  logic [AW-1:0]      base, rbase, vec_pc, next_pc, ent_pc;
  logic               irq_any;
  logic [LW-1:0]      irq_line;
  logic [CODE_W-1:0]  code;
  logic [CAUSE_W-1:0] st_cause;
  entry_e             kind;

  tec_irq_pick #(.N(NUM_IRQ), .LW(LW)) u_pick (
    .req_i (irq_lines_i & lie),
    .any_o (irq_any),
    .line_o(irq_line)
  );

  always_comb begin
    kind = ENT_NONE;
    if (trap_valid_i) begin
      if (trap_cause_i == CAUSE_DBG_BKPT) kind = ENT_DBG_BKPT;
      else if (trap_refill_i)             kind = ENT_REFILL;
      else                                kind = ENT_EXC;
    end else if (irq_any && ie_o) begin
      if (!dbg_mode_o)     kind = ENT_IRQ;
      else if (!dbg_irq_o) kind = ENT_DBG_IRQ;
    end
  end

  assign code = (kind == ENT_IRQ) ? CODE_W'(INT_BASE) + CODE_W'(irq_line)
                                  : CODE_W'(trap_cause_i);

  tec_vector #(.AW(AW), .CODE_W(CODE_W), .VS_W(VS_W)) u_vec (
    .base_i  (base),
    .code_i  (code),
    .vs_i    (vs),
    .target_o(vec_pc)
  );

  always_comb begin
    unique case (kind)
      ENT_EXC, ENT_IRQ:          next_pc = vec_pc;
      ENT_REFILL:                next_pc = rbase;
      ENT_DBG_BKPT, ENT_DBG_IRQ: next_pc = base + AW'(DBG_ENTRY_OFS);
      default:                   next_pc = new_pc_o;
    endcase
  end

  assign ent_pc   = trap_valid_i ? trap_pc_i : cur_pc_i;
  assign st_cause = trap_valid_i ? trap_cause_i : CAUSE_IRQ;

  tec_state #(.AW(AW), .IW(IW), .NUM_IRQ(NUM_IRQ), .VS_W(VS_W)) u_state (
    .clk_i, .rst_ni,
    .kind_i     (kind),
    .cause_i    (st_cause),
    .ent_pc_i   (ent_pc),
    .insn_i     (trap_insn_i),
    .badv_en_i  (trap_valid_i && loads_badv(trap_cause_i)),
    .badi_en_i  (trap_valid_i && (trap_cause_i != CAUSE_IF_PAGE)),
    .wr_en_i, .wr_sel_i, .wr_data_i,
    .plv_o, .ie_o, .da_o, .pg_o,
    .vs_o       (vs),
    .lie_o      (lie),
    .base_o     (base),
    .rbase_o    (rbase),
    .sv_plv_o, .sv_ie_o, .rf_sv_plv_o, .rf_sv_ie_o,
    .ecode_o, .epc_o, .rf_epc_o, .badv_o, .badi_o,
    .dbg_mode_o, .dbg_bkpt_o, .dbg_irq_o, .dbg_ecode_o, .depc_o
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      redirect_o <= 1'b0;
      new_pc_o   <= RESET_PC;
    end else begin
      redirect_o <= (kind != ENT_NONE);
      new_pc_o   <= next_pc;
    end
  end
endmodule

// File: rtl/tec_checker.sv
module tec_checker
  import tec_pkg::*;
#(
  parameter int unsigned AW = 32
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          trap_valid_i,
  input logic [5:0]    trap_cause_i,
  input logic [AW-1:0] trap_pc_i,
  input logic          trap_refill_i,
  input logic          redirect_o,
  input logic [1:0]    plv_o,
  input logic          ie_o,
  input logic          da_o,
  input logic          pg_o,
  input logic [5:0]    ecode_o,
  input logic [AW-1:0] epc_o,
  input logic [AW-3:0] rf_epc_o,
  input logic          dbg_mode_o,
  input logic          dbg_bkpt_o,
  input logic [5:0]    dbg_ecode_o,
  input logic [AW-1:0] depc_o
);
  AST_IRQ_NEEDS_IE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !trap_valid_i && !ie_o |=> !redirect_o); // R1

  AST_TRAP_REDIRECTS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trap_valid_i |=> redirect_o); // R12

  AST_ENTRY_DROPS_MODE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trap_valid_i && trap_cause_i != CAUSE_DBG_BKPT |=> !ie_o && plv_o == 2'd0); // R5

  AST_REFILL_STATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trap_valid_i && trap_refill_i && trap_cause_i != CAUSE_DBG_BKPT
    |=> da_o && !pg_o && rf_epc_o == $past(trap_pc_i[AW-1:2])); // R6

  AST_TRAP_RECORD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trap_valid_i && !trap_refill_i && trap_cause_i != CAUSE_DBG_BKPT
    |=> epc_o == $past(trap_pc_i) && ecode_o == $past(trap_cause_i)); // R7

  AST_BKPT_ENTRY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trap_valid_i && trap_cause_i == CAUSE_DBG_BKPT
    |=> dbg_mode_o && dbg_bkpt_o && dbg_ecode_o == 6'hC
        && depc_o == $past(trap_pc_i)); // R8
endmodule

bind trap_entry_ctrl tec_checker #(.AW(AW)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .trap_valid_i (trap_valid_i),
  .trap_cause_i (trap_cause_i),
  .trap_pc_i    (trap_pc_i),
  .trap_refill_i(trap_refill_i),
  .redirect_o   (redirect_o),
  .plv_o        (plv_o),
  .ie_o         (ie_o),
  .da_o         (da_o),
  .pg_o         (pg_o),
  .ecode_o      (ecode_o),
  .epc_o        (epc_o),
  .rf_epc_o     (rf_epc_o),
  .dbg_mode_o   (dbg_mode_o),
  .dbg_bkpt_o   (dbg_bkpt_o),
  .dbg_ecode_o  (dbg_ecode_o),
  .depc_o       (depc_o)
);

// File: tb/trap_entry_ctrl_test.sv
module trap_entry_ctrl_test;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        trap_valid_i = 1'b0;
  logic [5:0]  trap_cause_i = '0;
  logic [31:0] trap_pc_i = '0;
  logic [31:0] trap_insn_i = '0;
  logic        trap_refill_i = 1'b0;
  logic [31:0] cur_pc_i = '0;
  logic [12:0] irq_lines_i = '0;
  logic        wr_en_i = 1'b0;
  logic [2:0]  wr_sel_i = '0;
  logic [31:0] wr_data_i = '0;
  logic        redirect_o, ie_o, da_o, pg_o, sv_ie_o, rf_sv_ie_o;
  logic        dbg_mode_o, dbg_bkpt_o, dbg_irq_o;
  logic [1:0]  plv_o, sv_plv_o, rf_sv_plv_o;
  logic [5:0]  ecode_o, dbg_ecode_o;
  logic [31:0] new_pc_o, epc_o, badv_o, badi_o, depc_o;
  logic [29:0] rf_epc_o;

  int n_chk = 0;
  int n_err = 0;
  logic [31:0] exp_badv = '0;
  logic [31:0] exp_badi = '0;

  always #5 clk = ~clk;

  trap_entry_ctrl uut (
    .clk_i(clk), .rst_ni, .trap_valid_i, .trap_cause_i, .trap_pc_i, .trap_insn_i,
    .trap_refill_i, .cur_pc_i, .irq_lines_i, .wr_en_i, .wr_sel_i, .wr_data_i,
    .redirect_o, .new_pc_o, .plv_o, .ie_o, .da_o, .pg_o, .sv_plv_o, .sv_ie_o,
    .rf_sv_plv_o, .rf_sv_ie_o, .ecode_o, .epc_o, .rf_epc_o, .badv_o, .badi_o,
    .dbg_mode_o, .dbg_bkpt_o, .dbg_irq_o, .dbg_ecode_o, .depc_o
  );

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_err++;
      $display("FAIL %s got %h exp %h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [2:0] sel, input logic [31:0] data);
    @(negedge clk);
    wr_en_i = 1'b1; wr_sel_i = sel; wr_data_i = data;
    @(negedge clk);
    wr_en_i = 1'b0;
  endtask

  task automatic set_mode(input logic [1:0] plv, input logic ie, input logic da, input logic pg);
    wr(3'd0, {27'b0, pg, da, ie, plv});
  endtask

  task automatic set_cfg(input logic [2:0] vs, input logic [12:0] lie);
    wr(3'd1, {13'b0, vs, 3'b0, lie});
  endtask

  task automatic trap(input logic [5:0] c, input logic [31:0] pc,
                      input logic [31:0] insn, input logic refill);
    @(negedge clk);
    trap_valid_i = 1'b1; trap_cause_i = c; trap_pc_i = pc;
    trap_insn_i = insn; trap_refill_i = refill;
    @(negedge clk);
    trap_valid_i = 1'b0; trap_refill_i = 1'b0;
    if (c >= 6'd11 && c <= 6'd16) exp_badv = pc;
    if (c != 6'd3) exp_badi = insn;
  endtask

  function automatic logic [31:0] vec(input logic [31:0] b, input int code, input int vs);
    return (vs == 0) ? b : b + (32'(code) << (vs + 2));
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    logic [5:0]  causes [13] = '{6'd1, 6'd2, 6'd4, 6'd5, 6'd6, 6'd7, 6'd9,
                                 6'd11, 6'd12, 6'd13, 6'd14, 6'd15, 6'd16};
    int          vs_list [4] = '{0, 2, 5, 7};
    logic [31:0] base  = 32'h8000_0000;
    logic [31:0] rbase = 32'h9000_0100;
    logic [31:0] pc, old_epc;
    logic [5:0]  old_ecode;

    repeat (3) @(negedge clk);
    // R11 reset state
    chk("R11 pc", new_pc_o, 32'h1C00_0000);
    chk("R11 redirect", {31'b0, redirect_o}, 0);
    chk("R11 plv", {30'b0, plv_o}, 0);
    chk("R11 ie", {31'b0, ie_o}, 0);
    chk("R11 da", {31'b0, da_o}, 1);
    chk("R11 pg", {31'b0, pg_o}, 0);
    rst_ni = 1'b1;
    @(negedge clk);
    chk("R11 pc held", new_pc_o, 32'h1C00_0000);

    // R13 mode write fields
    set_mode(2'd1, 1'b0, 1'b0, 1'b1);
    chk("R13 plv", {30'b0, plv_o}, 1);
    chk("R13 da", {31'b0, da_o}, 0);
    chk("R13 pg", {31'b0, pg_o}, 1);

    // R11 lie reset to 0, R1 gating
    set_mode(2'd0, 1'b1, 1'b1, 1'b0);
    @(negedge clk); irq_lines_i = 13'h1FFF;
    @(negedge clk); chk("R11 lie=0 blocks irq", {31'b0, redirect_o}, 0);
    @(negedge clk); chk("R1 masked", {31'b0, redirect_o}, 0);
    irq_lines_i = 13'h1FFE;
    set_cfg(3'd0, 13'h0001);
    @(negedge clk); chk("R1 mask mismatch", {31'b0, redirect_o}, 0);
    irq_lines_i = 13'h0;
    set_mode(2'd0, 1'b0, 1'b1, 1'b0);
    set_cfg(3'd0, 13'h1FFF);
    irq_lines_i = 13'h0010;
    @(negedge clk);
    @(negedge clk); chk("R1 ie=0 blocks", {31'b0, redirect_o}, 0);
    irq_lines_i = 13'h0;

    // R11 vs=0: exception lands on base
    trap(6'd11, 32'h0000_1000, 32'h1, 1'b0);
    chk("R11 vs=0 vector", new_pc_o, 32'h0);
    @(negedge clk); chk("R12 one-cycle pulse", {31'b0, redirect_o}, 0);

    // R3 R5 R7 R10 exception sweep
    wr(3'd2, base);
    for (int v = 0; v < 8; v++) begin
      set_cfg(3'(v), 13'h0);
      for (int k = 0; k < 13; k++) begin
        set_mode(2'd3, 1'b1, 1'b1, 1'b0);
        pc = 32'h0010_0000 + 32'(v << 12) + 32'(k << 2);
        trap(causes[k], pc, 32'hA500_0000 | 32'(k), 1'b0);
        chk("R12 redirect", {31'b0, redirect_o}, 1);
        chk("R3 vector", new_pc_o, vec(base, int'(causes[k]), v));
        chk("R7 ecode", {26'b0, ecode_o}, {26'b0, causes[k]});
        chk("R7 epc", epc_o, pc);
        chk("R5 saved plv", {30'b0, sv_plv_o}, 3);
        chk("R5 saved ie", {31'b0, sv_ie_o}, 1);
        chk("R5 plv cleared", {30'b0, plv_o}, 0);
        chk("R5 ie cleared", {31'b0, ie_o}, 0);
        chk("R10 badv", badv_o, exp_badv);
        chk("R10 badi", badi_o, exp_badi);
      end
    end

    // R10 fetch page invalid keeps badi
    trap(6'd3, 32'h0044_0000, 32'hDEAD_BEEF, 1'b0);
    chk("R10 badi kept on cause 3", badi_o, exp_badi);
    chk("R10 badv kept on cause 3", badv_o, exp_badv);

    // R1 R2 R4 interrupt sweep
    for (int vi = 0; vi < 4; vi++) begin
      set_cfg(3'(vs_list[vi]), 13'h1FFF);
      for (int l = 0; l < 13; l++) begin
        set_mode(2'd2, 1'b1, 1'b1, 1'b0);
        cur_pc_i = 32'h0020_0000 + 32'(l << 2);
        @(negedge clk);
        irq_lines_i = 13'(1 << l) | (13'((1 << l) - 1) & 13'h0AAA);
        @(negedge clk);
        irq_lines_i = 13'h0;
        chk("R1 irq taken", {31'b0, redirect_o}, 1);
        chk("R2 R4 irq vector", new_pc_o, vec(base, 64 + l, vs_list[vi]));
        chk("R4 ecode", {26'b0, ecode_o}, 0);
        chk("R4 epc", epc_o, cur_pc_i);
        chk("R5 irq saved plv", {30'b0, sv_plv_o}, 2);
        chk("R5 irq ie cleared", {31'b0, ie_o}, 0);
        chk("R10 irq badi untouched", badi_o, exp_badi);
      end
    end

    // R6 refill
    wr(3'd3, rbase);
    set_mode(2'd2, 1'b1, 1'b0, 1'b1);
    old_epc = epc_o; old_ecode = ecode_o;
    trap(6'd1, 32'h1234_5678, 32'h77, 1'b1);
    chk("R6 pc", new_pc_o, rbase);
    chk("R6 rf_epc", {2'b0, rf_epc_o}, 32'h1234_5678 >> 2);
    chk("R6 da", {31'b0, da_o}, 1);
    chk("R6 pg", {31'b0, pg_o}, 0);
    chk("R6 rf saved plv", {30'b0, rf_sv_plv_o}, 2);
    chk("R6 rf saved ie", {31'b0, rf_sv_ie_o}, 1);
    chk("R6 epc kept", epc_o, old_epc);
    chk("R6 ecode kept", {26'b0, ecode_o}, {26'b0, old_ecode});
    chk("R5 refill plv", {30'b0, plv_o}, 0);

    // R12 trap beats irq, write dropped
    set_cfg(3'd1, 13'h1FFF);
    set_mode(2'd0, 1'b1, 1'b1, 1'b0);
    @(negedge clk);
    trap_valid_i = 1'b1; trap_cause_i = 6'd11; trap_pc_i = 32'h0055_0000;
    irq_lines_i = 13'h0001;
    wr_en_i = 1'b1; wr_sel_i = 3'd0; wr_data_i = 32'h0000_0007;
    @(negedge clk);
    trap_valid_i = 1'b0; wr_en_i = 1'b0; irq_lines_i = 13'h0;
    chk("R12 trap wins", new_pc_o, vec(base, 11, 1));
    chk("R12 trap ecode", {26'b0, ecode_o}, 11);
    chk("R12 write dropped plv", {30'b0, plv_o}, 0);
    chk("R12 write dropped ie", {31'b0, ie_o}, 0);
    @(negedge clk); chk("R12 no second pulse", {31'b0, redirect_o}, 0);

    // R8 breakpoint (refill flag ignored)
    set_mode(2'd1, 1'b1, 1'b1, 1'b0);
    trap(6'd26, 32'h0066_0040, 32'h5, 1'b1);
    chk("R8 pc", new_pc_o, base + 32'h480);
    chk("R8 dbg mode", {31'b0, dbg_mode_o}, 1);
    chk("R8 bkpt flag", {31'b0, dbg_bkpt_o}, 1);
    chk("R8 dbg ecode", {26'b0, dbg_ecode_o}, 32'hC);
    chk("R8 depc", depc_o, 32'h0066_0040);
    chk("R5 debug keeps plv", {30'b0, plv_o}, 1);
    chk("R5 debug keeps ie", {31'b0, ie_o}, 1);

    // R9 interrupt in debug mode
    cur_pc_i = 32'h0077_0000;
    @(negedge clk); irq_lines_i = 13'h0020;
    @(negedge clk);
    chk("R9 redirect", {31'b0, redirect_o}, 1);
    chk("R9 pc", new_pc_o, base + 32'h480);
    chk("R9 dbg irq flag", {31'b0, dbg_irq_o}, 1);
    chk("R9 depc", depc_o, 32'h0077_0000);
    @(negedge clk);
    chk("R9 no repeat", {31'b0, redirect_o}, 0);
    @(negedge clk);
    chk("R1 debug blocks vector", {31'b0, redirect_o}, 0);
    irq_lines_i = 13'h0;

    $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end
endmodule